// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block sits between a receive MAC and a local byte-wide buffer RAM. It treats a region of that RAM as a ring of fixed 256-byte pages that lie between a configured first page and an exclusive last page. For each incoming frame it skips four bytes at the start of the current page and stores the frame bytes from there onwards. The write address wraps from the end of the ring back to its first page. After the frame ends, it fills the four skipped bytes with a header: the receive status, the page where the following frame will start, and the 16-bit byte count, low byte first. Only then does it move its current-page register forward.

A consumer reads frames starting at the page after the boundary register. When it has finished with a frame, it hands back that frame's next-page value. The block sets the boundary one page behind that value, so the boundary trails the consumer by one page. The block never writes into the boundary page. If a frame needs that page, the frame is dropped, an overwrite flag is raised and reception stops until the flag is cleared. In monitor mode, frames are only counted and nothing is written.

The MAC supplies one data byte per `rx_valid` cycle. It ends a frame with a one-cycle `rx_end` strobe that carries the status byte, or with `rx_abort`. CRC bytes are passed on as ordinary data bytes.

Top module: `rx_page_ring`

## Requirements
- R1: While and after reset: current page equals `cfg_pstart`, boundary equals `cfg_pstop`-1, the overwrite flag is 0, the missed count is 0, `ring_empty` is 1, and `rx_busy` and `mem_we` are 0.
- R2: The first byte of a frame is written at offset 4 of the current page, and each further byte goes to the next address. `mem_addr` is {page, offset}. Each write appears on the memory port one cycle after its input cycle.
- R3: A byte that follows offset 255 of page `cfg_pstop`-1 is written at offset 0 of page `cfg_pstart`.
- R4: After `rx_end`, the four header bytes go to offsets 0,1,2,3 of the frame's start page, in four consecutive cycles: status (bit0 intact, bit1 CRC error, bit2 alignment error, bit3 FIFO overrun, bit4 missed, bit5 multicast, bit6 disabled, bit7 deferring, stored exactly as given), next page, count bits 7:0, count bits 15:8. `rx_busy` is high from the cycle after `rx_end` until the last header byte is written.
- R5: The byte count equals the number of data bytes delivered, including the 4 CRC bytes.
- R6: The next page is the page after the one holding the last data byte, wrapped to `cfg_pstart` at `cfg_pstop`.
- R7: The current page takes the next-page value on the same clock edge that puts the last header byte on the memory port. An aborted frame writes no header and leaves the current page unchanged.
- R8: `rel_we` sets the boundary to `rel_page`-1, or to `cfg_pstop`-1 when `rel_page` is not above `cfg_pstart`.
- R9: `ring_empty` is 1 exactly when the page after the boundary (wrapped) equals the current page.
- R10: The overwrite flag is set, and the frame is dropped with no further writes, no header and no page advance, in two cases: a frame starts while the current page equals the boundary, or a byte would enter the boundary page. A dropped frame counts as missed at its end. While the flag is set, new frames are dropped and counted. `ovw_clr` clears the flag.
- R11: With `cfg_monitor` high, a frame writes nothing and adds 1 to the missed count at its end.
- R12: When a byte enters a new page in the same cycle that `rel_we` moves the boundary, the overwrite test uses the boundary as it stood before that release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pstart | input | 8 | First page of the ring |
| cfg_pstop | input | 8 | Page just past the ring |
| cfg_monitor | input | 1 | Count frames without storing them |
| rx_valid | input | 1 | Data byte present |
| rx_data | input | 8 | Data byte |
| rx_end | input | 1 | Frame finished; status on rx_stat |
| rx_stat | input | 8 | Receive status byte |
| rx_abort | input | 1 | Frame abandoned |
| rx_busy | output | 1 | Header being written; input ignored |
| rel_we | input | 1 | Consumer hands back a frame |
| rel_page | input | 8 | Next-page value of the freed frame |
| ovw_clr | input | 1 | Clear overwrite flag |
| mem_we | output | 1 | Buffer RAM write strobe |
| mem_addr | output | 16 | Buffer RAM byte address {page, offset} |
| mem_wdata | output | 8 | Buffer RAM write data |
| curr_page | output | 8 | Current page register |
| bnd_page | output | 8 | Boundary register |
| ovw_flag | output | 1 | Overwrite warning |
| ring_empty | output | 1 | No unread frame |
| missed_cnt | output | 8 | Missed frame count (wraps) |

## Verification
The boundary release from the consumer and the writer's page-entry test can happen in the same cycle. Only the order between them decides whether a frame survives. The bench provokes this by pulsing `rel_we` on exactly the cycle in which a frame's 253rd byte crosses into a fresh page, with a release that makes that fresh page the new boundary. The design passes if the overwrite flag stays low, the byte is found in the buffer at the new page, and the header and page advance complete normally.

// File: rtl/rx_page_ring_pkg.sv
package rx_page_ring_pkg;
    localparam int PAGE_W    = 8;
    localparam int OFF_W     = 8;
    localparam int ADDR_W    = PAGE_W + OFF_W;
    localparam int DATA_W    = 8;
    localparam int LEN_W     = 2 * DATA_W;
    localparam int HDR_BYTES = 4;

    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef struct packed {
        page_t page;
        off_t  off;
    } baddr_t;

    typedef enum logic [1:0] {
        W_IDLE,
        W_DATA,
        W_HEAD,
        W_DROP
    } wr_state_e;

    function automatic page_t pg_inc(page_t p, page_t lo, page_t hi);
        page_t n;
        n = page_t'(p + 1'b1);
        return (n == hi) ? lo : n;
    endfunction

    function automatic page_t pg_dec(page_t p, page_t lo, page_t hi);
        return (p <= lo) ? page_t'(hi - 1'b1) : page_t'(p - 1'b1);
    endfunction

    function automatic baddr_t addr_inc(baddr_t a, page_t lo, page_t hi);
        baddr_t r;
        if (a.off == '1) begin
            r.page = pg_inc(a.page, lo, hi);
            r.off  = '0;
        end else begin
            r.page = a.page;
            r.off  = off_t'(a.off + 1'b1);
        end
        return r;
    endfunction
endpackage

// File: rtl/rx_ring_ptrs.sv
module rx_ring_ptrs
    import rx_page_ring_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  page_t pstart,
    input  page_t pstop,
    input  logic  commit,
    input  page_t commit_page,
    input  logic  rel_we,
    input  page_t rel_page,
    input  logic  ovw_hit,
    input  logic  ovw_clr,
    output page_t curr,
    output page_t bnd,
    output logic  ovw,
    output logic  empty
);
    always_ff @(posedge clk) begin
        if (rst) begin
            curr <= pstart;
            bnd  <= page_t'(pstop - 1'b1);
            ovw  <= 1'b0;
        end else begin
            if (commit)
                curr <= commit_page;
            if (rel_we)
                bnd <= pg_dec(rel_page, pstart, pstop);
            if (ovw_hit)
                ovw <= 1'b1;
            else if (ovw_clr)
                ovw <= 1'b0;
        end
    end

    assign empty = (pg_inc(bnd, pstart, pstop) == curr);

    // R7
    curr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> curr == $past(curr));

    // R6
    curr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (curr >= pstart) && (curr < pstop));

    // R10
    ovw_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovw && !ovw_clr) |=> ovw);
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rx_page_ring_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  page_t pstart,
    input  page_t pstop,
    input  logic  monitor,
    input  page_t curr,
    input  page_t bnd,
    input  logic  ovw,
    input  logic  rx_valid,
    input  byte_t rx_data,
    input  logic  rx_end,
    input  byte_t rx_stat,
    input  logic  rx_abort,
    output logic  rx_busy,
    output logic  mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output byte_t mem_wdata,
    output logic  commit,
    output page_t commit_page,
    output logic  ovw_hit,
    output logic  miss
);
    wr_state_e st;
    baddr_t    ptr;
    baddr_t    mem_a;
    page_t     base;
    page_t     nxt_pg;
    len_t      cnt;
    byte_t     stat_q;
    logic [1:0] hidx;
    byte_t     hdr_byte;
    baddr_t    first_a;

    assign first_a.page = curr;
    assign first_a.off  = off_t'(HDR_BYTES);

    always_comb begin
        case (hidx)
            2'd0:    hdr_byte = stat_q;
            2'd1:    hdr_byte = byte_t'(nxt_pg);
            2'd2:    hdr_byte = cnt[DATA_W-1:0];
            default: hdr_byte = cnt[LEN_W-1:DATA_W];
        endcase
    end

    always_comb begin
        commit  = (st == W_HEAD) && (hidx == 2'd3);
        ovw_hit = 1'b0;
        if (st == W_IDLE && rx_valid && !monitor && !ovw && curr == bnd)
            ovw_hit = 1'b1;
        if (st == W_DATA && !rx_abort && !rx_end && rx_valid &&
            ptr.off == '0 && ptr.page == bnd)
            ovw_hit = 1'b1;
        miss = (st == W_DROP) && rx_end && !rx_abort;
    end

    assign commit_page = nxt_pg;
    assign rx_busy     = (st == W_HEAD);
    assign mem_addr    = mem_a;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= W_IDLE;
            ptr       <= '0;
            mem_a     <= '0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
            base      <= '0;
            nxt_pg    <= '0;
            cnt       <= '0;
            stat_q    <= '0;
            hidx      <= '0;
        end else begin
            mem_we <= 1'b0;
            case (st)
                W_IDLE: begin
                    if (rx_valid) begin
                        if (monitor || ovw || curr == bnd) begin
                            st <= W_DROP;
                        end else begin
                            mem_we    <= 1'b1;
                            mem_a     <= first_a;
                            mem_wdata <= rx_data;
                            ptr       <= addr_inc(first_a, pstart, pstop);
                            base      <= curr;
                            cnt       <= len_t'(1);
                            st        <= W_DATA;
                        end
                    end
                end
                W_DATA: begin
                    if (rx_abort) begin
                        st <= W_IDLE;
                    end else if (rx_end) begin
                        stat_q <= rx_stat;
                        nxt_pg <= (ptr.off == '0) ? ptr.page
                                                  : pg_inc(ptr.page, pstart, pstop);
                        hidx   <= '0;
                        st     <= W_HEAD;
                    end else if (rx_valid) begin
                        if (ptr.off == '0 && ptr.page == bnd) begin
                            st <= W_DROP;
                        end else begin
                            mem_we    <= 1'b1;
                            mem_a     <= ptr;
                            mem_wdata <= rx_data;
                            ptr       <= addr_inc(ptr, pstart, pstop);
                            cnt       <= len_t'(cnt + 1'b1);
                        end
                    end
                end
                W_HEAD: begin
                    mem_we     <= 1'b1;
                    mem_a.page <= base;
                    mem_a.off  <= off_t'(hidx);
                    mem_wdata  <= hdr_byte;
                    hidx       <= hidx + 2'd1;
                    if (hidx == 2'd3)
                        st <= W_IDLE;
                end
                default: begin
                    if (rx_abort || rx_end)
                        st <= W_IDLE;
                end
            endcase
        end
    end

    // R10
    no_bnd_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_a.page != $past(bnd));

    // R11
    monitor_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == W_IDLE && monitor && rx_valid) |=> !mem_we);

    // R7
    abort_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (st == W_DATA && rx_abort) |=> !commit && !mem_we);
endmodule

// File: rtl/rx_miss_counter.sv
module rx_miss_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             miss,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (miss)
            cnt <= cnt + 1'b1;
    end

    // R11
    miss_inc_chk: assert property (@(posedge clk) disable iff (rst)
        miss |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/rx_page_ring.sv
module rx_page_ring
    import rx_page_ring_pkg::*;
#(
    parameter int MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PAGE_W-1:0] cfg_pstart,
    input  logic [PAGE_W-1:0] cfg_pstop,
    input  logic              cfg_monitor,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_end,
    input  logic [DATA_W-1:0] rx_stat,
    input  logic              rx_abort,
    output logic              rx_busy,
    input  logic              rel_we,
    input  logic [PAGE_W-1:0] rel_page,
    input  logic              ovw_clr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [PAGE_W-1:0] curr_page,
    output logic [PAGE_W-1:0] bnd_page,
    output logic              ovw_flag,
    output logic              ring_empty,
    output logic [MISS_W-1:0] missed_cnt
);
    logic  commit;
    page_t commit_page;
    logic  ovw_hit;
    logic  miss;

    rx_ring_ptrs u_ptrs (
        .clk         (clk),
        .rst         (rst),
        .pstart      (cfg_pstart),
        .pstop       (cfg_pstop),
        .commit      (commit),
        .commit_page (commit_page),
        .rel_we      (rel_we),
        .rel_page    (rel_page),
        .ovw_hit     (ovw_hit),
        .ovw_clr     (ovw_clr),
        .curr        (curr_page),
        .bnd         (bnd_page),
        .ovw         (ovw_flag),
        .empty       (ring_empty)
    );

    rx_ring_writer u_writer (
        .clk         (clk),
        .rst         (rst),
        .pstart      (cfg_pstart),
        .pstop       (cfg_pstop),
        .monitor     (cfg_monitor),
        .curr        (curr_page),
        .bnd         (bnd_page),
        .ovw         (ovw_flag),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_end      (rx_end),
        .rx_stat     (rx_stat),
        .rx_abort    (rx_abort),
        .rx_busy     (rx_busy),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .commit      (commit),
        .commit_page (commit_page),
        .ovw_hit     (ovw_hit),
        .miss        (miss)
    );

    rx_miss_counter #(.CNT_W(MISS_W)) u_miss (
        .clk  (clk),
        .rst  (rst),
        .miss (miss),
        .cnt  (missed_cnt)
    );
endmodule

// File: tb/rx_page_ring_tb.sv
module rx_page_ring_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_pstart = 8'h10;
    logic [7:0]  cfg_pstop  = 8'h14;
    logic        cfg_monitor = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_end = 1'b0;
    logic [7:0]  rx_stat = '0;
    logic        rx_abort = 1'b0;
    logic        rx_busy;
    logic        rel_we = 1'b0;
    logic [7:0]  rel_page = '0;
    logic        ovw_clr = 1'b0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  curr_page;
    logic [7:0]  bnd_page;
    logic        ovw_flag;
    logic        ring_empty;
    logic [7:0]  missed_cnt;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int stray = 0;
    bit done = 0;
    logic [7:0] mem_model [0:1023];

    always #5 clk = ~clk;

    rx_page_ring u_dut (
        .clk(clk), .rst(rst), .cfg_pstart(cfg_pstart), .cfg_pstop(cfg_pstop),
        .cfg_monitor(cfg_monitor), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_end(rx_end), .rx_stat(rx_stat), .rx_abort(rx_abort), .rx_busy(rx_busy),
        .rel_we(rel_we), .rel_page(rel_page), .ovw_clr(ovw_clr), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .curr_page(curr_page),
        .bnd_page(bnd_page), .ovw_flag(ovw_flag), .ring_empty(ring_empty),
        .missed_cnt(missed_cnt)
    );

    always @(negedge clk) begin
        if (!rst && mem_we) begin
            wr_cnt = wr_cnt + 1;
            if (mem_addr[15:8] < 8'h10 || mem_addr[15:8] >= 8'h14)
                stray = stray + 1;
            mem_model[{mem_addr[9:8], mem_addr[7:0]}] = mem_wdata;
        end
    end

    function automatic logic [7:0] dbyte(int fid, int i);
        return 8'((i * 7 + fid * 31) & 255);
    endfunction

    function automatic int loc(int page, int i);
        return ((page - 16) * 256 + 3 + i) % 1024;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic release_pg(logic [7:0] p);
        @(negedge clk); rel_we = 1'b1; rel_page = p;
        @(negedge clk); rel_we = 1'b0;
    endtask

    task automatic clear_ovw();
        @(negedge clk); ovw_clr = 1'b1;
        @(negedge clk); ovw_clr = 1'b0;
    endtask

    task automatic send_frame(int fid, int n, logic [7:0] st, bit abort,
                              int rel_at, logic [7:0] rel_v);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = dbyte(fid, i);
            rel_we   = (i == rel_at);
            rel_page = rel_v;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rel_we   = 1'b0;
        if (abort) rx_abort = 1'b1;
        else begin rx_end = 1'b1; rx_stat = st; end
        @(negedge clk);
        rx_end = 1'b0;
        rx_abort = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        check(curr_page == 8'h10, "R1 curr", curr_page, 8'h10);
        check(bnd_page == 8'h13, "R1 bnd", bnd_page, 8'h13);
        check(!ovw_flag && missed_cnt == 0, "R1 ovw/missed", {ovw_flag, missed_cnt}, 0);
        check(ring_empty && !rx_busy && !mem_we, "R1 empty/busy/we",
              {ring_empty, rx_busy, mem_we}, 3'b100);
    endtask

    task automatic t_small();
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = dbyte(1, i);
        end
        @(negedge clk); rx_valid = 1'b0; rx_end = 1'b1; rx_stat = 8'h21;
        @(negedge clk); rx_end = 1'b0;
        check(rx_busy == 1'b1, "R4 busy after end", rx_busy, 1);
        repeat (3) @(negedge clk);
        check(curr_page == 8'h10 && rx_busy, "R7 curr held during header",
              curr_page, 8'h10);
        @(negedge clk);
        check(curr_page == 8'h11, "R7 curr on last header edge", curr_page, 8'h11);
        check(mem_we && mem_addr == 16'h1003 && !rx_busy, "R7 last header write",
              mem_addr, 16'h1003);
        repeat (4) @(negedge clk);
        check(mem_model[4] == dbyte(1, 1), "R2 first byte at offset 4", mem_model[4], dbyte(1, 1));
        check(mem_model[9] == dbyte(1, 6), "R2 sequential bytes", mem_model[9], dbyte(1, 6));
        check(mem_model[0] == 8'h21, "R4 status byte", mem_model[0], 8'h21);
        check(mem_model[1] == 8'h11, "R6 next page", mem_model[1], 8'h11);
        check({mem_model[3], mem_model[2]} == 16'd6, "R5 count", {mem_model[3], mem_model[2]}, 6);
        check(!ring_empty, "R9 not empty", ring_empty, 0);
    endtask

    task automatic t_long_wrap();
        release_pg(8'h11);
        check(bnd_page == 8'h10, "R8 release plain", bnd_page, 8'h10);
        send_frame(2, 600, 8'h01, 0, 0, 0);
        check(mem_model[257] == 8'h10, "R6 next page wraps", mem_model[257], 8'h10);
        check({mem_model[259], mem_model[258]} == 16'd600, "R5 long count",
              {mem_model[259], mem_model[258]}, 600);
        check(mem_model[loc(8'h11, 600)] == dbyte(2, 600), "R2 last byte", mem_model[loc(8'h11, 600)], dbyte(2, 600));
        release_pg(8'h10);
        check(bnd_page == 8'h13, "R8 release at start wraps", bnd_page, 8'h13);
        check(ring_empty, "R9 empty after release", ring_empty, 1);
        send_frame(3, 300, 8'h01, 0, 0, 0);
        check(mem_model[1] == 8'h12, "R6 next page frame3", mem_model[1], 8'h12);
        release_pg(8'h12);
        send_frame(4, 600, 8'h01, 0, 0, 0);
        check(mem_model[0] == dbyte(4, 509), "R3 wrap to first page", mem_model[0], dbyte(4, 509));
        check(mem_model[513] == 8'h11 && curr_page == 8'h11, "R6 R7 frame4 next",
              curr_page, 8'h11);
        check(stray == 0, "R3 no write outside ring", stray, 0);
    endtask

    task automatic t_overwrite();
        int wc;
        wc = wr_cnt;
        send_frame(5, 5, 8'h01, 0, 0, 0);
        check(ovw_flag, "R10 full at start", ovw_flag, 1);
        check(wr_cnt == wc && curr_page == 8'h11, "R10 nothing stored", wr_cnt - wc, 0);
        check(missed_cnt == 1, "R10 missed count", missed_cnt, 1);
        clear_ovw();
        release_pg(8'h11);
        wc = wr_cnt;
        send_frame(6, 800, 8'h01, 0, 0, 0);
        check(ovw_flag && missed_cnt == 2, "R10 page entry hit", missed_cnt, 2);
        check(wr_cnt - wc == 764, "R10 writes stop at boundary", wr_cnt - wc, 764);
        check(mem_model[0] == dbyte(4, 509), "R10 boundary page untouched", mem_model[0], dbyte(4, 509));
        check(curr_page == 8'h11, "R10 curr unchanged", curr_page, 8'h11);
        wc = wr_cnt;
        send_frame(7, 4, 8'h01, 0, 0, 0);
        check(wr_cnt == wc && missed_cnt == 3, "R10 drop while flagged", missed_cnt, 3);
        clear_ovw();
        check(!ovw_flag, "R10 clear", ovw_flag, 0);
    endtask

    task automatic t_same_cycle();
        send_frame(8, 253, 8'h01, 0, 253, 8'h13);
        check(!ovw_flag, "R12 no overwrite", ovw_flag, 0);
        check(mem_model[512] == dbyte(8, 253), "R12 byte stored", mem_model[512], dbyte(8, 253));
        check(curr_page == 8'h13 && bnd_page == 8'h12, "R12 pointers",
              {curr_page, bnd_page}, 16'h1312);
        check(mem_model[258] == 8'hFD && mem_model[257] == 8'h13, "R12 header",
              mem_model[258], 8'hFD);
    endtask

    task automatic t_monitor();
        int wc;
        wc = wr_cnt;
        cfg_monitor = 1'b1;
        send_frame(10, 5, 8'h01, 0, 0, 0);
        cfg_monitor = 1'b0;
        check(wr_cnt == wc, "R11 no writes", wr_cnt - wc, 0);
        check(missed_cnt == 4, "R11 missed", missed_cnt, 4);
    endtask

    task automatic t_abort();
        int wc;
        wc = wr_cnt;
        send_frame(9, 10, 8'h01, 1, 0, 0);
        check(wr_cnt - wc == 10, "R7 abort no header", wr_cnt - wc, 10);
        check(curr_page == 8'h13, "R7 abort keeps curr", curr_page, 8'h13);
        check(mem_model[772] == dbyte(9, 1), "R2 abort data", mem_model[772], dbyte(9, 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_small();
        t_long_wrap();
        t_overwrite();
        t_same_cycle();
        t_monitor();
        t_abort();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule